// File: doc/BRIEF.md
# Lockable Round-Robin Translation Buffer

This block is a small, fully associative address translation buffer for a device-side memory management unit. It holds either 8 or 32 entries. Each entry pairs a tag word with a data word. The tag word holds a virtual page base, a valid flag and a page-size code. The data word holds the physical page base. Four page sizes are available: 4 KB, 64 KB, 1 MB and 16 MB. A lookup port compares a device virtual address against all valid entries in parallel and returns the translated address, or a miss strobe, on the next cycle.

Software controls the buffer through a set of register-style strobes:
- It stages a tag word and a data word.
- It writes a lock register that holds a base index and a victim index.
- It issues load, preserved-load, single-flush and global-flush commands.

Entries below the base are preserved. Ordinary loads refill the region at and above the base in round-robin order through the victim index. Software reads any entry back by pointing the victim index at it.

Top module: `xlat_lockbuf`

## Requirements
- R1: After reset every entry is invalid, `lock_rdata` reads 0, `rb_tag` and `rb_data` read 0, and every lookup misses.
- R2: `lock_rdata` shows the base index in bits 14:10 and the victim index in bits 8:4, with every other bit 0. A `lock_we` strobe loads both indices from the same bit positions of `lock_wdata`, and ignores all other bits. A written index above the entry count is held at the entry count.
- R3: An accepted ordinary load copies the staged tag word and data word into the entry at the victim index. `rb_tag` and `rb_data` always show the entry at the victim index, or 0 when the victim index is not below the entry count.
- R4: After an accepted ordinary load the victim index rises by one. If it would reach the entry count, it becomes the base index instead of 0.
- R5: A preserved load writes the staged words into the entry at the base index, then sets both the base and the victim to the old base plus one. When the base equals the entry count, both preserved and ordinary loads are ignored and leave the lock state unchanged. An ordinary load is also ignored when the victim is not below the entry count.
- R6: Tag word layout: bits 31:12 hold the virtual page base, bit 2 holds the valid flag, and bits 1:0 hold the size code (00 = 4 KB, 01 = 64 KB, 10 = 1 MB, 11 = 16 MB). Data word bits 31:12 hold the physical base. Only the address bits above the page offset are compared.
- R7: A lookup presented with `lk_valid` produces `lk_hit` one cycle later. At that point `lk_pa` equals the physical base bits above the page offset joined with the lookup address bits below it.
- R8: A lookup that matches no valid entry raises `lk_miss` one cycle later, with `lk_miss_va` equal to the looked-up address. `lk_hit` and `lk_miss` are never high together.
- R9: When several valid entries match, the entry with the lowest index supplies the translation.
- R10: A single flush clears the valid flag of every valid entry whose mapped range contains the staged address (staged tag bits 31:12 with a zero offset). Other entries are left unchanged.
- R11: A global flush clears every valid flag and sets both base and victim to 0. Tag and data contents other than the valid flag are kept.
- R12: When several commands arrive in one cycle, only the highest-priority one acts. The order, from highest to lowest, is: global flush, lock write, preserved load, ordinary load, single flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stage_tag_we | input | 1 | Capture `stage_tag_in` into the staged tag |
| stage_tag_in | input | 32 | Tag word to stage |
| stage_data_we | input | 1 | Capture `stage_data_in` into the staged data |
| stage_data_in | input | 32 | Data word to stage |
| lock_we | input | 1 | Write the lock register |
| lock_wdata | input | 32 | Lock register write value |
| lock_rdata | output | 32 | Lock register read value |
| cmd_load | input | 1 | Ordinary load into the victim entry |
| cmd_load_keep | input | 1 | Preserved load into the base entry |
| cmd_flush_one | input | 1 | Flush the entries covering the staged address |
| cmd_flush_all | input | 1 | Flush all entries and clear the lock register |
| rb_tag | output | 32 | Tag word of the entry at the victim index |
| rb_data | output | 32 | Data word of the entry at the victim index |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit strobe |
| lk_miss | output | 1 | Lookup miss strobe |
| lk_pa | output | 32 | Translated address, valid with `lk_hit` |
| lk_miss_va | output | 32 | Address that missed, valid with `lk_miss` |

## Verification
A corrupted base or victim index shows up on `lock_rdata` in the cycle after the command that caused it. One load later, it also shows up as the wrong entry being overwritten: a lookup that should hit misses, or a stale translation survives. A valid flag that is wrongly set or cleared shows up in the very next lookup of an address in that page, and in `rb_tag` bit 2 once the victim index points at that entry. Faults in page-size masking or in match priority only appear for addresses inside overlapping or large pages, so the stimulus covers all four sizes and an overlapping pair of entries.

// File: rtl/xb_pkg.sv
package xb_pkg;
   localparam int AW        = 32;
   localparam int VALID_BIT = 2;
   localparam int PAGE_LSB  = 12;
   localparam int LOCK_BASE_LSB = 10;
   localparam int LOCK_VICT_LSB = 4;
   localparam int LOCK_FLD_W    = 5;

   typedef enum logic [1:0] {
      PG_4K  = 2'd0,
      PG_64K = 2'd1,
      PG_1M  = 2'd2,
      PG_16M = 2'd3
   } pg_size_e;

   // number of untranslated offset bits for a size code
   function automatic int unsigned pg_offset_bits(pg_size_e s);
      case (s)
         PG_4K:   return 12;
         PG_64K:  return 16;
         PG_1M:   return 20;
         default: return 24;
      endcase
   endfunction

   // mask selecting the translated (page base) bits
   function automatic logic [AW-1:0] pg_mask(pg_size_e s);
      return ~((AW'(1) << pg_offset_bits(s)) - AW'(1));
   endfunction
endpackage

// File: rtl/xb_match.sv
module xb_match
   import xb_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0][AW-1:0] tags,
   input  logic [AW-1:0]        addr,
   output logic [N-1:0]         hits
);
   for (genvar g = 0; g < N; g++) begin : g_ent
      logic [AW-1:0] msk;
      assign msk     = pg_mask(pg_size_e'(tags[g][1:0]));
      assign hits[g] = tags[g][VALID_BIT] && ((tags[g] & msk) == (addr & msk));
   end
endmodule

// File: rtl/xb_pick.sv
module xb_pick #(
   parameter int N = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/xb_lock.sv
module xb_lock
   import xb_pkg::*;
#(
   parameter int N = 8,
   localparam int IW = $clog2(N),
   localparam int CW = IW + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush_all,
   input  logic                  lock_we,
   input  logic [LOCK_FLD_W-1:0] base_in,
   input  logic [LOCK_FLD_W-1:0] vict_in,
   input  logic                  ld,
   input  logic                  ld_keep,
   output logic [CW-1:0]         base,
   output logic [CW-1:0]         vict,
   output logic                  wr_en,
   output logic [IW-1:0]         wr_idx
);
   logic [CW-1:0] base_q, vict_q;
   logic          ctl, keep_ok, norm_ok;
   logic [CW-1:0] vict_inc, base_inc;

   function automatic logic [CW-1:0] clamp(logic [LOCK_FLD_W-1:0] v);
      return (int'(v) > N) ? CW'(N) : CW'(v);
   endfunction

   assign ctl      = !flush_all && !lock_we;
   assign keep_ok  = ctl && ld_keep && (base_q < CW'(N));
   assign norm_ok  = ctl && ld && !ld_keep && (base_q < CW'(N)) && (vict_q < CW'(N));
   assign vict_inc = vict_q + CW'(1);
   assign base_inc = base_q + CW'(1);
   assign wr_en    = keep_ok || norm_ok;
   assign wr_idx   = keep_ok ? base_q[IW-1:0] : vict_q[IW-1:0];
   assign base     = base_q;
   assign vict     = vict_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         vict_q <= '0;
      end else if (flush_all) begin
         base_q <= '0;
         vict_q <= '0;
      end else if (lock_we) begin
         base_q <= clamp(base_in);
         vict_q <= clamp(vict_in);
      end else if (keep_ok) begin
         base_q <= base_inc;
         vict_q <= base_inc;
      end else if (norm_ok) begin
         vict_q <= (vict_inc == CW'(N)) ? base_q : vict_inc;
      end
   end

   AST_VICT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (norm_ok && vict_q == CW'(N - 1)) |=> (vict_q == $past(base_q))); // R4
   AST_BASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      base_q <= CW'(N)); // R5
   AST_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl && (ld || ld_keep) && base_q == CW'(N)) |=> ($stable(base_q) && $stable(vict_q))); // R5
   AST_GF_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (base_q == '0 && vict_q == '0)); // R11
endmodule

// File: rtl/xlat_lockbuf.sv
module xlat_lockbuf
   import xb_pkg::*;
#(
   parameter int ENTRIES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        stage_tag_we,
   input  logic [31:0] stage_tag_in,
   input  logic        stage_data_we,
   input  logic [31:0] stage_data_in,
   input  logic        lock_we,
   input  logic [31:0] lock_wdata,
   output logic [31:0] lock_rdata,
   input  logic        cmd_load,
   input  logic        cmd_load_keep,
   input  logic        cmd_flush_one,
   input  logic        cmd_flush_all,
   output logic [31:0] rb_tag,
   output logic [31:0] rb_data,
   input  logic        lk_valid,
   input  logic [31:0] lk_va,
   output logic        lk_hit,
   output logic        lk_miss,
   output logic [31:0] lk_pa,
   output logic [31:0] lk_miss_va
);
   localparam int IW = $clog2(ENTRIES);
   localparam int CW = IW + 1;

   initial begin
      AST_ENTRY_COUNT: assert (ENTRIES == 8 || ENTRIES == 32); // R2
   end

   logic [ENTRIES-1:0][AW-1:0] tags_q, data_q;
   logic [AW-1:0]              stg_tag, stg_data, flush_addr;
   logic [CW-1:0]              base, vict;
   logic                       wr_en;
   logic [IW-1:0]              wr_idx;
   logic [ENTRIES-1:0]         lk_vec, fl_vec, vld;
   logic                       lk_any;
   logic [IW-1:0]              lk_idx;
   logic                       fl_ok;
   logic [AW-1:0]              hit_msk;
   logic                       unused_lock;

   assign unused_lock = ^{lock_wdata[31:15], lock_wdata[9], lock_wdata[3:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_tag  <= '0;
         stg_data <= '0;
      end else begin
         if (stage_tag_we)  stg_tag  <= stage_tag_in;
         if (stage_data_we) stg_data <= stage_data_in;
      end
   end

   xb_lock #(.N(ENTRIES)) i_lock (
      .clk(clk), .rst_n(rst_n),
      .flush_all(cmd_flush_all), .lock_we(lock_we),
      .base_in(lock_wdata[LOCK_BASE_LSB +: LOCK_FLD_W]),
      .vict_in(lock_wdata[LOCK_VICT_LSB +: LOCK_FLD_W]),
      .ld(cmd_load), .ld_keep(cmd_load_keep),
      .base(base), .vict(vict), .wr_en(wr_en), .wr_idx(wr_idx)
   );

   assign lock_rdata = {17'b0, LOCK_FLD_W'(base), 1'b0, LOCK_FLD_W'(vict), 4'b0};

   assign flush_addr = {stg_tag[AW-1:PAGE_LSB], PAGE_LSB'(0)};
   assign fl_ok = cmd_flush_one && !cmd_flush_all && !lock_we && !cmd_load_keep && !cmd_load;

   xb_match #(.N(ENTRIES)) i_lk_match (.tags(tags_q), .addr(lk_va),      .hits(lk_vec));
   xb_match #(.N(ENTRIES)) i_fl_match (.tags(tags_q), .addr(flush_addr), .hits(fl_vec));
   xb_pick  #(.N(ENTRIES)) i_pick     (.vec(lk_vec), .any(lk_any), .idx(lk_idx));

   for (genvar g = 0; g < ENTRIES; g++) begin : g_store
      assign vld[g] = tags_q[g][VALID_BIT];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tags_q[g] <= '0;
            data_q[g] <= '0;
         end else if (cmd_flush_all) begin
            tags_q[g][VALID_BIT] <= 1'b0;
         end else if (wr_en && wr_idx == IW'(g)) begin
            tags_q[g] <= stg_tag;
            data_q[g] <= stg_data;
         end else if (fl_ok && fl_vec[g]) begin
            tags_q[g][VALID_BIT] <= 1'b0;
         end
      end
   end

   always_comb begin
      rb_tag  = '0;
      rb_data = '0;
      if (vict < CW'(ENTRIES)) begin
         rb_tag  = tags_q[vict[IW-1:0]];
         rb_data = data_q[vict[IW-1:0]];
      end
   end

   assign hit_msk = pg_mask(pg_size_e'(tags_q[lk_idx][1:0]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_hit     <= 1'b0;
         lk_miss    <= 1'b0;
         lk_pa      <= '0;
         lk_miss_va <= '0;
      end else begin
         lk_hit  <= lk_valid && lk_any;
         lk_miss <= lk_valid && !lk_any;
         if (lk_valid && lk_any)  lk_pa      <= (data_q[lk_idx] & hit_msk) | (lk_va & ~hit_msk);
         if (lk_valid && !lk_any) lk_miss_va <= lk_va;
      end
   end

   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss)); // R8
   AST_MISS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> (lk_miss_va == $past(lk_va))); // R8
   AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit || lk_miss) |-> $past(lk_valid)); // R7
   AST_GF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_flush_all |=> ($countones(vld) == 0)); // R11
   AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_ok && !$onehot0(fl_vec)) |=> ($countones(vld) < $countones($past(vld)))); // R10
endmodule

// File: tb/test_xlat_lockbuf.sv
module test_xlat_lockbuf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stage_tag_we = 0, stage_data_we = 0, lock_we = 0;
   logic [31:0] stage_tag_in = '0, stage_data_in = '0, lock_wdata = '0;
   logic        cmd_load = 0, cmd_load_keep = 0, cmd_flush_one = 0, cmd_flush_all = 0;
   logic        lk_valid = 0;
   logic [31:0] lk_va = '0;
   logic [31:0] lock_rdata, rb_tag, rb_data, lk_pa, lk_miss_va;
   logic        lk_hit, lk_miss;

   int errs = 0;
   int checks = 0;

   typedef struct {
      logic        hit;
      logic [31:0] val;
      string       req;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   xlat_lockbuf #(.ENTRIES(8)) i_xlat_lockbuf (
      .clk(clk), .rst_n(rst_n),
      .stage_tag_we(stage_tag_we), .stage_tag_in(stage_tag_in),
      .stage_data_we(stage_data_we), .stage_data_in(stage_data_in),
      .lock_we(lock_we), .lock_wdata(lock_wdata), .lock_rdata(lock_rdata),
      .cmd_load(cmd_load), .cmd_load_keep(cmd_load_keep),
      .cmd_flush_one(cmd_flush_one), .cmd_flush_all(cmd_flush_all),
      .rb_tag(rb_tag), .rb_data(rb_data),
      .lk_valid(lk_valid), .lk_va(lk_va),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_miss_va(lk_miss_va)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a lookup result appears
   always @(negedge clk) begin
      if (rst_n && (lk_hit || lk_miss)) begin
         if (sb.size() == 0) begin
            chk("R7 unexpected strobe", {30'b0, lk_hit, lk_miss}, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.req, " hit flag"}, {31'b0, lk_hit}, {31'b0, e.hit});
            if (e.hit) chk({e.req, " pa"}, lk_pa, e.val);
            else       chk({e.req, " miss va"}, lk_miss_va, e.val);
         end
      end
   end

   task automatic lookup(input logic [31:0] va, input logic eh, input logic [31:0] ep, input string req);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_va    = va;
      sb.push_back('{eh, eh ? ep : va, req});
      @(negedge clk);
      lk_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic stage(input logic [31:0] t, input logic [31:0] d);
      @(negedge clk);
      stage_tag_we = 1; stage_tag_in = t; stage_data_we = 1; stage_data_in = d;
      @(negedge clk);
      stage_tag_we = 0; stage_data_we = 0;
   endtask

   task automatic cmd(input logic ld, input logic keep, input logic fo, input logic fa, input logic lw, input logic [31:0] lv);
      @(negedge clk);
      cmd_load = ld; cmd_load_keep = keep; cmd_flush_one = fo; cmd_flush_all = fa;
      lock_we = lw; lock_wdata = lv;
      @(negedge clk);
      cmd_load = 0; cmd_load_keep = 0; cmd_flush_one = 0; cmd_flush_all = 0; lock_we = 0;
   endtask

   task automatic load(input logic [31:0] t, input logic [31:0] d);
      stage(t, d);
      cmd(1, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 lock", lock_rdata, 32'h0);
      chk("R1 rb_tag", rb_tag, 32'h0);
      chk("R1 rb_data", rb_data, 32'h0);
      lookup(32'h0001_0ABC, 0, 0, "R1 empty lookup");

      // R5 preserved load into entry 0
      stage(32'h0001_0004, 32'h8000_0000);
      cmd(0, 1, 0, 0, 0, 0);
      chk("R5 base/vict after keep", lock_rdata, 32'h0000_0410);
      // R3/R4 ordinary loads
      load(32'h0002_0004, 32'h9000_0000);
      chk("R4 victim step", lock_rdata, 32'h0000_0420);
      lookup(32'h0001_0ABC, 1, 32'h8000_0ABC, "R7 4K hit e0");
      lookup(32'h0002_0123, 1, 32'h9000_0123, "R7 4K hit e1");
      // R6 page sizes
      load(32'h0030_0005, 32'hA005_0000);
      load(32'h0100_0006, 32'hB010_0000);
      load(32'h0500_0007, 32'hC000_0000);
      lookup(32'h0030_F00C, 1, 32'hA005_F00C, "R6 64K");
      lookup(32'h010A_BCDE, 1, 32'hB01A_BCDE, "R6 1M");
      lookup(32'h05FE_DCBA, 1, 32'hC0FE_DCBA, "R6 16M");
      // R9 overlap, entry 5 inside entry 2
      load(32'h0030_0004, 32'hD000_0000);
      lookup(32'h0030_0010, 1, 32'hA005_0010, "R9 lowest index");
      // fill to wrap
      load(32'h0600_0004, 32'hE000_0000);
      load(32'h0700_0004, 32'hF000_0000);
      chk("R4 wrap to base", lock_rdata, 32'h0000_0410);
      load(32'h0800_0004, 32'h1234_5000);
      chk("R4 after wrap", lock_rdata, 32'h0000_0420);
      lookup(32'h0002_0123, 0, 0, "R3 overwritten e1");
      lookup(32'h0800_0055, 1, 32'h1234_5055, "R3 new e1");
      // R2 lock write with junk bits, R3 readback
      cmd(0, 0, 0, 0, 1, 32'hFFFF_867F);
      chk("R2 lock fields", lock_rdata, 32'h0000_0470);
      chk("R3 rb_tag e7", rb_tag, 32'h0700_0004);
      chk("R3 rb_data e7", rb_data, 32'hF000_0000);
      // R10 single flush by range
      stage(32'h0030_F000, 32'h0);
      cmd(0, 0, 1, 0, 0, 0);
      lookup(32'h0030_0010, 1, 32'hD000_0010, "R10 64K gone, 4K kept");
      cmd(0, 0, 0, 0, 1, 32'h0000_0420);
      chk("R10 e2 valid cleared", rb_tag, 32'h0030_0001);
      stage(32'h0030_0000, 32'h0);
      cmd(0, 0, 1, 0, 0, 0);
      lookup(32'h0030_0010, 0, 0, "R10 4K flushed");
      lookup(32'h0001_0ABC, 1, 32'h8000_0ABC, "R10 others kept");
      // R12 lock write beats preserved load
      stage(32'h0900_0004, 32'h1111_1000);
      cmd(0, 1, 0, 0, 1, 32'h0);
      chk("R12 lock write wins", lock_rdata, 32'h0);
      lookup(32'h0900_0000, 0, 0, "R12 keep suppressed");
      lookup(32'h0001_0ABC, 1, 32'h8000_0ABC, "R12 e0 intact");
      // R11/R12 global flush beats load
      cmd(1, 0, 0, 1, 0, 0);
      chk("R11 pointers zero", lock_rdata, 32'h0);
      chk("R11 e0 tag kept, invalid", rb_tag, 32'h0001_0000);
      lookup(32'h0001_0ABC, 0, 0, "R11 e0 flushed");
      lookup(32'h0900_0000, 0, 0, "R12 load suppressed");
      // R5 full preserved region
      cmd(0, 0, 0, 0, 1, 32'h0000_2080);
      chk("R5 base at count", lock_rdata, 32'h0000_2080);
      cmd(0, 1, 0, 0, 0, 0);
      chk("R5 keep rejected", lock_rdata, 32'h0000_2080);
      cmd(1, 0, 0, 0, 0, 0);
      chk("R5 load rejected", lock_rdata, 32'h0000_2080);
      chk("R3 rb out of range", rb_tag, 32'h0);
      lookup(32'h0900_0000, 0, 0, "R5 nothing written");

      repeat (4) @(negedge clk);
      chk("R7 scoreboard drained", sb.size(), 32'h0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule